// File: doc/BRIEF.md
# Circular trace capture buffer

This block stores a stream of trace frames in an on-chip circular RAM. Capture runs while the enable bit is set. Every accepted frame passes through a short input formatter pipeline and is then written at the write pointer. The pointer wraps to the start of the RAM, so the buffer always holds the most recent frames.

A frame can carry a trigger mark. Once a marked frame is stored, a post-trigger counter counts down on each further stored frame. When it reaches zero, acquisition is complete and the RAM stops accepting writes. This keeps a chosen amount of history on both sides of the trigger event.

A small word-wide register bus gives software control of the block. Software loads the post-trigger count, clears the write pointer and sets the enable bit. It then polls the status flags: wrapped, triggered, complete and formatter drained. Finally it reads the RAM out through a data register whose read pointer advances on every access.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, the status register reads 8 (only the drained flag set), and the control, read pointer, write pointer and trigger counter registers read 0.
- R2: The register addresses are: 0 identification, 1 depth, 2 data width, 3 status, 4 RAM data, 5 read pointer, 6 write pointer, 7 trigger counter, 8 control. Address 0 returns ID_VALUE, 1 returns DEPTH and 2 returns WIDTH, and writes to these three have no effect.
- R3: Each stored frame advances the write pointer by one. From DEPTH-1 it goes to 0 and sets the wrapped flag (status bit 0), which then holds until capture is re-enabled.
- R4: Status bit 1 (triggered) sets when a frame presented with `frame_trig` high is stored.
- R5: After the trigger frame, each further stored frame decrements the trigger counter. The frame that brings it to zero sets status bit 2 (complete). A count of 0 completes on the trigger frame itself. Complete never stands without triggered.
- R6: Once complete is set, no further frame changes the RAM or the write pointer, even with enable still 1.
- R7: Status bit 3 (drained) is 1 exactly when the formatter holds no frame. A frame reaches the RAM FMT_STAGES cycles after it is accepted.
- R8: A read of address 4 returns the word at the read pointer, zero-extended. The read pointer then advances by one modulo DEPTH. Reads of other addresses leave it unchanged.
- R9: Writes to the read or write pointer keep only the low log2(DEPTH) bits of the data (DEPTH is a power of two).
- R10: Control bit 0 is enable and bit 1 is the port-mode select; both read back. Setting enable when it was 0 clears status bits 0 to 2. With enable at 0, new frames are ignored, but frames already in the formatter are still stored.
- R11: After a wrap, reading DEPTH words starting at the write pointer returns the stored frames oldest first.
- R12: Addresses 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | Trace frame strobe |
| frame_trig | input | 1 | Trigger mark for the frame |
| frame_data | input | WIDTH | Trace frame |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |

## Verification
The hardest case to reach is a capture that wraps the RAM, then triggers, then finishes its post-trigger count. The stored history must then read back in order across the RAM boundary, starting at the write pointer. The bench overrides DEPTH to 16 and streams more than one full buffer of numbered frames. It then sends the trigger and keeps sending frames past completion. Finally it reads DEPTH words from the write pointer and expects a single unbroken run of frame numbers.

// File: rtl/trc_pkg.sv
// Shared register addresses and flag positions of the trace capture buffer.
package trc_pkg;
    typedef enum logic [3:0] {
        RA_IDENT  = 4'd0,
        RA_DEPTH  = 4'd1,
        RA_WIDTH  = 4'd2,
        RA_STATUS = 4'd3,
        RA_DATA   = 4'd4,
        RA_RDPTR  = 4'd5,
        RA_WRPTR  = 4'd6,
        RA_TRGCNT = 4'd7,
        RA_CTRL   = 4'd8
    } trc_addr_e;

    localparam int SB_WRAPPED = 0;
    localparam int SB_TRIGGED = 1;
    localparam int SB_DONE    = 2;
    localparam int SB_DRAINED = 3;

    localparam int CB_ENABLE  = 0;
    localparam int CB_PORTSEL = 1;
endpackage

// File: rtl/trc_formatter.sv
// Input formatter: a STAGES-deep pipeline carrying frame, trigger mark and valid.
// Assumes STAGES >= 1. A frame enters only while in_accept is high.
module trc_formatter #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_trig,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_accept,
    output logic             out_valid,
    output logic             out_trig,
    output logic [WIDTH-1:0] out_data,
    output logic             empty
);
    logic             v_q [STAGES];
    logic             t_q [STAGES];
    logic [WIDTH-1:0] d_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Load the first stage from the frame input.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[0] <= 1'b0;
                    t_q[0] <= 1'b0;
                end else begin
                    v_q[0] <= in_valid && in_accept;
                    t_q[0] <= in_valid && in_accept && in_trig;
                end
                d_q[0] <= in_data;
            end
        end else begin : g_next
            // Shift from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[i] <= 1'b0;
                    t_q[i] <= 1'b0;
                end else begin
                    v_q[i] <= v_q[i-1];
                    t_q[i] <= t_q[i-1];
                end
                d_q[i] <= d_q[i-1];
            end
        end
    end

    // Drained when no stage holds a frame.
    always_comb begin
        empty = 1'b1;
        for (int i = 0; i < STAGES; i++) begin
            if (v_q[i]) empty = 1'b0;
        end
    end

    assign out_valid = v_q[STAGES-1];
    assign out_trig  = t_q[STAGES-1];
    assign out_data  = d_q[STAGES-1];
endmodule

// File: rtl/trc_store.sv
// Trace RAM: one synchronous write port, one combinational read port, no reset.
module trc_store #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store a frame when the controller commits it.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trc_ctrl.sv
// Capture controller and register file: pointers, trigger countdown, status flags,
// bus decode. Assumes DEPTH is a power of two and WIDTH <= 32.
module trc_ctrl
    import trc_pkg::*;
#(
    parameter int          WIDTH    = 24,
    parameter int          DEPTH    = 64,
    parameter logic [31:0] ID_VALUE = 32'h5443_0001,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             fmt_valid,
    input  logic             fmt_trig,
    input  logic             fmt_empty,
    output logic             fmt_accept,
    output logic             ram_we,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic             st_full,
    output logic             st_trig,
    output logic             st_done
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic        ctl_en, ctl_port;
    logic [31:0] trg_cnt;
    logic        rd_req, wr_req, en_rise, wp_sw, rp_sw, data_rd;
    logic        finish_now;

    assign rd_req  = bus_sel && !bus_wr;
    assign wr_req  = bus_sel && bus_wr;
    assign en_rise = wr_req && (bus_addr == RA_CTRL) && bus_wdata[CB_ENABLE] && !ctl_en;
    assign wp_sw   = wr_req && (bus_addr == RA_WRPTR);
    assign rp_sw   = wr_req && (bus_addr == RA_RDPTR);
    assign data_rd = rd_req && (bus_addr == RA_DATA);

    assign fmt_accept = ctl_en && !st_done;
    assign ram_we     = fmt_valid && !st_done;

    // This stored frame ends the acquisition.
    assign finish_now = ram_we &&
                        ((st_trig && trg_cnt <= 32'd1) ||
                         (!st_trig && fmt_trig && trg_cnt == 32'd0));

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_port <= 1'b0;
        end else if (wr_req && bus_addr == RA_CTRL) begin
            ctl_en   <= bus_wdata[CB_ENABLE];
            ctl_port <= bus_wdata[CB_PORTSEL];
        end
    end

    // Post-trigger countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trg_cnt <= '0;
        end else if (wr_req && bus_addr == RA_TRGCNT) begin
            trg_cnt <= bus_wdata;
        end else if (ram_we && st_trig && trg_cnt != 32'd0) begin
            trg_cnt <= trg_cnt - 32'd1;
        end
    end

    // Write pointer: software load, else advance with wrap per stored frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wp_sw) begin
            wr_ptr <= bus_wdata[PTR_W-1:0];
        end else if (ram_we) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Read pointer: software load, else advance on each data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rp_sw) begin
            rd_ptr <= bus_wdata[PTR_W-1:0];
        end else if (data_rd) begin
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Sticky status flags, cleared when capture is switched on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_full <= 1'b0;
            st_trig <= 1'b0;
            st_done <= 1'b0;
        end else if (en_rise) begin
            st_full <= 1'b0;
            st_trig <= 1'b0;
            st_done <= 1'b0;
        end else begin
            if (ram_we && wr_ptr == LAST && !wp_sw) st_full <= 1'b1;
            if (ram_we && fmt_trig)                 st_trig <= 1'b1;
            if (finish_now)                         st_done <= 1'b1;
        end
    end

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_IDENT:  bus_rdata = ID_VALUE;
            RA_DEPTH:  bus_rdata = 32'(DEPTH);
            RA_WIDTH:  bus_rdata = 32'(WIDTH);
            RA_STATUS: begin
                bus_rdata[SB_WRAPPED] = st_full;
                bus_rdata[SB_TRIGGED] = st_trig;
                bus_rdata[SB_DONE]    = st_done;
                bus_rdata[SB_DRAINED] = fmt_empty;
            end
            RA_DATA:   bus_rdata = 32'(ram_rdata);
            RA_RDPTR:  bus_rdata = 32'(rd_ptr);
            RA_WRPTR:  bus_rdata = 32'(wr_ptr);
            RA_TRGCNT: bus_rdata = trg_cnt;
            RA_CTRL: begin
                bus_rdata[CB_ENABLE]  = ctl_en;
                bus_rdata[CB_PORTSEL] = ctl_port;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trace_capture_buf.sv
// Top of the circular trace capture buffer: formatter, controller and RAM.
// Assumes DEPTH is a power of two, WIDTH <= 32, FMT_STAGES >= 1.
module trace_capture_buf #(
    parameter int          WIDTH      = 24,
    parameter int          DEPTH      = 64,
    parameter int          FMT_STAGES = 2,
    parameter logic [31:0] ID_VALUE   = 32'h5443_0001,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             frame_trig,
    input  logic [WIDTH-1:0] frame_data,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata
);
    logic             fmt_valid, fmt_trig, fmt_empty, fmt_accept;
    logic [WIDTH-1:0] fmt_data, ram_rdata;
    logic             ram_we, st_full, st_trig, st_done;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    trc_formatter #(.WIDTH(WIDTH), .STAGES(FMT_STAGES)) u_fmt (
        .clk(clk), .rst_n(rst_n),
        .in_valid(frame_valid), .in_trig(frame_trig), .in_data(frame_data),
        .in_accept(fmt_accept),
        .out_valid(fmt_valid), .out_trig(fmt_trig), .out_data(fmt_data),
        .empty(fmt_empty)
    );

    trc_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ID_VALUE(ID_VALUE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fmt_valid(fmt_valid), .fmt_trig(fmt_trig), .fmt_empty(fmt_empty),
        .fmt_accept(fmt_accept),
        .ram_we(ram_we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ram_rdata(ram_rdata),
        .st_full(st_full), .st_trig(st_trig), .st_done(st_done)
    );

    trc_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(wr_ptr), .wdata(fmt_data),
        .raddr(rd_ptr), .rdata(ram_rdata)
    );
endmodule

// File: rtl/trace_capture_buf_sva.sv
// Checker for the trace capture buffer, bound to the top module.
// Assumes the same DEPTH as the instance it is bound to.
module trace_capture_buf_sva #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             ram_we,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             st_full,
    input logic             st_trig,
    input logic             st_done
);
    logic any_wr, wp_wr, rp_wr, ctl_wr, dat_rd;
    assign any_wr = bus_sel && bus_wr;
    assign wp_wr  = any_wr && bus_addr == 4'd6;
    assign rp_wr  = any_wr && bus_addr == 4'd5;
    assign ctl_wr = any_wr && bus_addr == 4'd8;
    assign dat_rd = bus_sel && !bus_wr && bus_addr == 4'd4;

    AST_DONE_HAS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> st_trig); // R5

    AST_NO_STORE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_done && !wp_wr |=> wr_ptr == $past(wr_ptr)); // R6

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && wr_ptr == PTR_W'(DEPTH - 1) && !wp_wr && !ctl_wr
        |=> wr_ptr == '0 && st_full); // R3

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_full && !ctl_wr |=> st_full); // R3

    AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd && !rp_wr |=> rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)); // R8

    AST_DEPTH_RO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr == 4'd1 |-> bus_rdata == 32'(DEPTH)); // R2
endmodule

bind trace_capture_buf trace_capture_buf_sva #(.DEPTH(DEPTH)) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ram_we(ram_we),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .st_full(st_full),
    .st_trig(st_trig), .st_done(st_done)
);

// File: tb/trace_capture_buf_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares at negedge.
module trace_capture_buf_tb;
    localparam int          WIDTH = 20;
    localparam int          DEPTH = 16;
    localparam logic [31:0] IDV   = 32'h7C0A_0051;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0, frame_trig = 1'b0;
    logic [WIDTH-1:0] frame_data = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    trace_capture_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FMT_STAGES(2), .ID_VALUE(IDV)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_trig(frame_trig),
        .frame_data(frame_data), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Monitor: compare each read against the front of the queue.
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_wr) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s addr %0d actual 0x%08h expected 0x%08h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic push_frame(input logic [WIDTH-1:0] d, input logic tr);
        frame_valid = 1'b1; frame_trig = tr; frame_data = d;
        @(posedge clk); #1;
        frame_valid = 1'b0; frame_trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        bus_read(4'd3, 32'd8, "R1 status");
        bus_read(4'd8, 32'd0, "R1 control");
        bus_read(4'd5, 32'd0, "R1 rdptr");
        bus_read(4'd6, 32'd0, "R1 wrptr");
        bus_read(4'd7, 32'd0, "R1 trgcnt");
        // R2 read-only identity registers
        bus_read(4'd0, IDV, "R2 ident");
        bus_write(4'd1, 32'd99);
        bus_write(4'd2, 32'd7);
        bus_read(4'd1, 32'd16, "R2 depth");
        bus_read(4'd2, 32'd20, "R2 width");
        // R12 unmapped
        bus_write(4'd12, 32'hFFFF_FFFF);
        bus_read(4'd12, 32'd0, "R12 unmapped");
        // R10 port mode readback, R9 pointer modulo
        bus_write(4'd8, 32'd2);
        bus_read(4'd8, 32'd2, "R10 portsel");
        bus_write(4'd6, 32'd21);
        bus_read(4'd6, 32'd5, "R9 wrptr mod");

        // Capture without wrap, count 3
        bus_write(4'd7, 32'd3);
        bus_write(4'd6, 32'd0);
        bus_write(4'd8, 32'd1);
        push_frame(20'h100, 1'b0);
        bus_read(4'd3, 32'd0, "R7 busy");
        for (int i = 1; i < 5; i++) push_frame(20'h100 + 20'(i), 1'b0);
        idle(3);
        bus_read(4'd3, 32'd8, "R7 drained");
        bus_read(4'd6, 32'd5, "R3 wrptr");
        push_frame(20'h105, 1'b1);
        for (int i = 6; i < 11; i++) push_frame(20'h100 + 20'(i), 1'b0);
        idle(3);
        bus_read(4'd3, 32'd14, "R5 complete");
        bus_read(4'd6, 32'd9, "R6 stop");
        bus_read(4'd7, 32'd0, "R5 count");
        bus_write(4'd5, 32'd0);
        for (int i = 0; i < 9; i++) bus_read(4'd4, 32'h100 + 32'(i), "R8 data");
        bus_read(4'd5, 32'd9, "R8 rdptr");

        // Wrap then trigger, count 2
        bus_write(4'd8, 32'd0);
        bus_write(4'd7, 32'd2);
        bus_write(4'd6, 32'd0);
        bus_write(4'd8, 32'd1);
        bus_read(4'd3, 32'd8, "R10 clear");
        for (int i = 0; i < 20; i++) push_frame(20'h200 + 20'(i), 1'b0);
        idle(3);
        bus_read(4'd3, 32'd9, "R3 wrapped");
        bus_read(4'd6, 32'd4, "R3 wrap ptr");
        push_frame(20'h214, 1'b1);
        for (int i = 21; i < 25; i++) push_frame(20'h200 + 20'(i), 1'b0);
        idle(3);
        bus_read(4'd3, 32'd15, "R4 trig");
        bus_read(4'd6, 32'd7, "R6 wrap stop");
        bus_write(4'd5, 32'd7);
        for (int k = 0; k < 16; k++) bus_read(4'd4, 32'h207 + 32'(k), "R11 oldest");
        bus_read(4'd5, 32'd7, "R8 rd wrap");

        // Zero count completes on trigger frame
        bus_write(4'd8, 32'd0);
        bus_write(4'd7, 32'd0);
        bus_write(4'd6, 32'd0);
        bus_write(4'd8, 32'd1);
        push_frame(20'h300, 1'b1);
        push_frame(20'h301, 1'b0);
        idle(3);
        bus_read(4'd3, 32'd14, "R5 zero");
        bus_read(4'd6, 32'd1, "R5 zero ptr");
        bus_write(4'd5, 32'd0);
        bus_read(4'd4, 32'h300, "R5 zero data");

        // Disable mid-capture
        bus_write(4'd8, 32'd0);
        bus_write(4'd6, 32'd0);
        bus_write(4'd8, 32'd1);
        for (int i = 0; i < 3; i++) push_frame(20'h400 + 20'(i), 1'b0);
        bus_write(4'd8, 32'd0);
        idle(3);
        for (int i = 0; i < 3; i++) push_frame(20'h410 + 20'(i), 1'b1);
        idle(3);
        bus_read(4'd6, 32'd3, "R10 stop ptr");
        bus_read(4'd3, 32'd8, "R10 stop status");
        bus_write(4'd5, 32'd2);
        bus_read(4'd4, 32'h402, "R10 flush");
        bus_read(4'd4, 32'h213, "R10 ignored");

        idle(2);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule